// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block caches recent virtual-to-physical page mappings beside the address translation unit. An 8-bit virtual page number is presented on the lookup port; the block splits it into a set index (low bits) and a tag (high bits), compares the tag against every way of the chosen set at once, and one clock later reports either a hit with the stored 6-bit physical page number or a miss. A miss tells the surrounding logic to fetch the page-table entry from memory. A hit needs no memory access.

When the external page walker has the missing mapping, it presents the page number and physical page on the fill port, and the block installs it in the indexed set. If the tag is already there, that way is updated in place. Otherwise the lowest free way is used, or, when the set is full, the way chosen by a per-set rotating pointer. A flush input drops every mapping in one cycle. The default geometry holds 16 mappings as 4 sets of 4 ways.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every lookup, for any page number, reports a miss.
- R2: The set index is page number bits [1:0] and the tag is bits [7:2]. A lookup whose index and tag match a valid entry reports a hit with that entry's physical page. For example, virtual address 0x03D4 gives page 0x0F, index 3 and tag 0x03, and after a fill of page 0x0F with physical page 0x0D it hits with 0x0D.
- R3: rsp_valid is high exactly in the cycle after a cycle with lk_valid high. The response reflects the contents before any fill or flush applied at the same edge.
- R4: A response that is not a hit has rsp_hit low and rsp_ppn zero. Without a response, rsp_hit is low.
- R5: A fill whose tag is absent from its set writes the lowest-numbered invalid way of that set, if the set has one, and leaves the rotating pointer unchanged.
- R6: A fill into a full set with an absent tag replaces the way named by that set's 2-bit pointer, then advances the pointer by one modulo 4. Pointers are 0 after reset and are not changed by a flush.
- R7: A fill whose tag is already valid in its set overwrites that way's physical page. It creates no second copy and does not move the pointer.
- R8: A flush invalidates every entry in one cycle, so a lookup issued in the following cycle misses.
- R9: When a fill and a flush arrive in the same cycle, the flush wins and the fill is dropped.
- R10: A fill changes only its own set. The entries of every other set keep their mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 8 | Virtual page number to translate |
| fill_valid | input | 1 | Install-mapping strobe from the walker |
| fill_vpn | input | 8 | Virtual page number being installed |
| fill_ppn | input | 6 | Physical page number being installed |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_ppn | output | 6 | Physical page number on a hit, zero otherwise |

## Verification
The hardest state to reach from the ports is a full set whose rotating pointer is not at way 0 while free ways and pointer position are both in play. The pointer is invisible, and only its effect on which tag disappears can be seen. The stimulus overfills each set so the pointer moves, flushes, then refills the same set with more tags than it has ways. A full page-number sweep afterwards shows which earlier tag was evicted. That eviction is checked against a bench model that applies the free-way and pointer rules separately from the design.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W = 8;
    localparam int IDX_W = 2;
    localparam int PPN_W = 6;
    localparam int WAYS  = 4;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        ppn_t ppn;
    } entry_t;

    function automatic idx_t idx_of(input vpn_t v);
        return v[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input vpn_t v);
        return v[VPN_W-1:IDX_W];
    endfunction

    // lowest set bit position; zero when none set
    function automatic way_t lowest_one(input logic [WAYS-1:0] v);
        way_t r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = way_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  entry_t [WAYS-1:0] set_i,
    input  tag_t              tag_i,
    output logic [WAYS-1:0]   hit_o,
    output ppn_t              ppn_o
);
    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_o[w] = set_i[w].valid && (set_i[w].tag == tag_i);
        end
    endgenerate

    always_comb begin
        ppn_o = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_o[i]) ppn_o = ppn_o | set_i[i].ppn;
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
    import tlb_pkg::*;
(
    input  entry_t [WAYS-1:0] set_i,
    input  tag_t              tag_i,
    input  way_t              ptr_i,
    output way_t              way_o,
    output logic              advance_o
);
    logic [WAYS-1:0] same_tag;
    logic [WAYS-1:0] free_way;
    ppn_t            unused_ppn;

    tlb_way_match u_match (
        .set_i (set_i),
        .tag_i (tag_i),
        .hit_o (same_tag),
        .ppn_o (unused_ppn)
    );

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_free
            assign free_way[w] = ~set_i[w].valid;
        end
    endgenerate

    always_comb begin
        if (|same_tag) begin
            way_o     = lowest_one(same_tag);
            advance_o = 1'b0;
        end else if (|free_way) begin
            way_o     = lowest_one(free_way);
            advance_o = 1'b0;
        end else begin
            way_o     = ptr_i;
            advance_o = 1'b1;
        end
    end

    logic unused_ok;
    assign unused_ok = ^unused_ppn;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn
);
    entry_t [SETS-1:0][WAYS-1:0] mem_q;
    way_t   [SETS-1:0]           rr_q;

    // lookup path
    idx_t            lk_idx;
    logic [WAYS-1:0] lk_hit;
    ppn_t            lk_ppn;
    logic            lk_any;

    assign lk_idx = idx_of(lk_vpn);

    tlb_way_match u_lookup (
        .set_i (mem_q[lk_idx]),
        .tag_i (tag_of(lk_vpn)),
        .hit_o (lk_hit),
        .ppn_o (lk_ppn)
    );

    assign lk_any = lk_valid && (|lk_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_any;
            rsp_ppn   <= lk_any ? lk_ppn : '0;
        end
    end

    // fill path
    idx_t fl_idx;
    tag_t fl_tag;
    way_t fl_way;
    logic fl_adv;

    assign fl_idx = idx_of(fill_vpn);
    assign fl_tag = tag_of(fill_vpn);

    tlb_victim_pick u_pick (
        .set_i     (mem_q[fl_idx]),
        .tag_i     (fl_tag),
        .ptr_i     (rr_q[fl_idx]),
        .way_o     (fl_way),
        .advance_o (fl_adv)
    );

    logic [SETS*WAYS-1:0] valid_flat;

    genvar s, w;
    generate
        for (s = 0; s < SETS; s++) begin : g_set
            logic wr_here;
            assign wr_here = fill_valid && !flush && (fl_idx == idx_t'(s));

            always_ff @(posedge clk) begin
                if (rst) begin
                    rr_q[s] <= '0;
                end else if (wr_here && fl_adv) begin
                    rr_q[s] <= rr_q[s] + way_t'(1);
                end
            end

            for (w = 0; w < WAYS; w++) begin : g_way
                always_ff @(posedge clk) begin
                    if (rst) begin
                        mem_q[s][w] <= '0;
                    end else if (flush) begin
                        mem_q[s][w].valid <= 1'b0;
                    end else if (wr_here && (fl_way == way_t'(w))) begin
                        mem_q[s][w] <= '{valid: 1'b1, tag: fl_tag, ppn: fill_ppn};
                    end
                end
                assign valid_flat[s*WAYS + w] = mem_q[s][w].valid;
            end
        end
    endgenerate
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 lk_valid,
    input logic                 flush,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [PPN_W-1:0]     rsp_ppn,
    input logic [SETS*WAYS-1:0] valid_flat,
    input logic [WAYS-1:0]      lk_hit
);
    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R3
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R4
    miss_ppn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));

    // R4
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_flat == '0));

    // R7
    single_way_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));
endmodule

bind tlb_xlate tlb_xlate_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .flush      (flush),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ppn    (rsp_ppn),
    .valid_flat (valid_flat),
    .lk_hit     (lk_hit)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lk_valid = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       fill_valid = 1'b0;
    logic [7:0] fill_vpn = '0;
    logic [5:0] fill_ppn = '0;
    logic       flush = 1'b0;
    logic       rsp_valid;
    logic       rsp_hit;
    logic [5:0] rsp_ppn;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // reference state built from the requirements
    logic       m_val [4][4];
    logic [5:0] m_tag [4][4];
    logic [5:0] m_ppn [4][4];
    logic [1:0] m_ptr [4];

    always #5 clk = ~clk;

    tlb_xlate dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn)
    );

    task automatic check(input string rq, input logic [7:0] v,
                         input logic ah, input logic eh,
                         input logic [5:0] ap, input logic [5:0] ep);
        vectors++;
        if (ah !== eh || ap !== ep) begin
            misses++;
            $display("FAIL %s vpn=%02h hit=%b exp %b ppn=%02h exp %02h", rq, v, ah, eh, ap, ep);
        end
    endtask

    task automatic model_flush();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
    endtask

    task automatic model_fill(input logic [7:0] v, input logic [5:0] p);
        int s, way, found;
        s = int'(v[1:0]);
        found = -1;
        for (int w = 0; w < 4; w++)
            if (m_val[s][w] && m_tag[s][w] == v[7:2]) found = w;
        if (found >= 0) begin
            way = found;
        end else begin
            way = -1;
            for (int w = 3; w >= 0; w--)
                if (!m_val[s][w]) way = w;
            if (way < 0) begin
                way = int'(m_ptr[s]);
                m_ptr[s] = m_ptr[s] + 2'd1;
            end
        end
        m_val[s][way] = 1'b1;
        m_tag[s][way] = v[7:2];
        m_ppn[s][way] = p;
    endtask

    task automatic expect_of(input logic [7:0] v, output logic h, output logic [5:0] p);
        int s;
        s = int'(v[1:0]);
        h = 1'b0;
        p = '0;
        for (int w = 0; w < 4; w++)
            if (m_val[s][w] && m_tag[s][w] == v[7:2]) begin
                h = 1'b1;
                p = m_ppn[s][w];
            end
    endtask

    task automatic do_fill(input logic [7:0] v, input logic [5:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
        @(negedge clk);
        fill_valid = 1'b0;
        model_fill(v, p);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_flush();
    endtask

    task automatic look(input logic [7:0] v, input string rq);
        logic       eh;
        logic [5:0] ep;
        expect_of(v, eh, ep);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 1'b0;
        vectors++;
        if (rsp_valid !== 1'b1) begin
            misses++;
            $display("FAIL R3 vpn=%02h rsp_valid=%b exp 1", v, rsp_valid);
        end
        check(rq, v, rsp_hit, eh, rsp_ppn, ep);
    endtask

    task automatic sweep(input string rq);
        for (int v = 0; v < 256; v++) look(8'(v), rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            m_ptr[s] = 2'd0;
            for (int w = 0; w < 4; w++) begin
                m_val[s][w] = 1'b0; m_tag[s][w] = '0; m_ppn[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        vectors++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            misses++;
            $display("FAIL R1 rsp_valid=%b rsp_hit=%b exp 0 0", rsp_valid, rsp_hit);
        end
        sweep("R1");

        // R2: address 0x03D4 -> page 0x0F, index 3, tag 0x03
        do_fill(8'h0F, 6'h0D);
        look(8'h0F, "R2");
        check("R2", 8'h0F, 1'b1, 1'b1, rsp_ppn, 6'h0D);
        look(8'h0E, "R2");

        // R5 R10: fill every set to capacity
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                do_fill({6'(k * 5 + s + 1), 2'(s)}, 6'(k * 7 + s * 3 + 2));
        sweep("R5");

        // R6: overfill so the pointer moves
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < s + 1; k++)
                do_fill({6'(40 + k * 3 + s), 2'(s)}, 6'(k + s * 11 + 1));
        sweep("R6");

        // R7: rewrite a resident tag, then one more new tag
        do_fill({6'(40 + 2), 2'd2}, 6'h3F);
        do_fill({6'(1 * 5 + 3 + 1), 2'd3}, 6'h2A);
        look({6'(40 + 2), 2'd2}, "R7");
        do_fill({6'h3E, 2'd2}, 6'h15);
        sweep("R7");

        // R8: flush then immediate lookup
        do_flush();
        sweep("R8");

        // R5 R6: refill after flush, pointer kept
        for (int k = 0; k < 6; k++) do_fill({6'(20 + k), 2'd1}, 6'(k + 30));
        for (int k = 0; k < 5; k++) do_fill({6'(50 + k), 2'd2}, 6'(k + 9));
        sweep("R6");

        // R9: fill and flush together
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 8'hA5; fill_ppn = 6'h21;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        model_flush();
        look(8'hA5, "R9");
        sweep("R9");

        // R3: lookup at the same edge as the fill sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 8'h5A;
        fill_valid = 1'b1; fill_vpn = 8'h5A; fill_ppn = 6'h33;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        check("R3", 8'h5A, rsp_hit, 1'b0, rsp_ppn, 6'h00);
        model_fill(8'h5A, 6'h33);
        look(8'h5A, "R3");
        check("R3", 8'h5A, rsp_hit, 1'b1, rsp_ppn, 6'h33);

        // R4: idle cycle gives no response
        @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_ppn !== 6'h00) begin
            misses++;
            $display("FAIL R4 idle rsp=%b/%b/%02h exp 0/0/00", rsp_valid, rsp_hit, rsp_ppn);
        end
        sweep("R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule